// File: doc/BRIEF.md
# Instruction Address Sequencer with Conditional Branch

This block keeps the address of the instruction being executed and moves it forward once per clock. On an ordinary cycle it steps to the next address. When the processor asks for a relative branch, it tests one status flag. If that flag is set, it adds a signed offset taken from the instruction word. When the processor asks for an absolute jump, it loads a target value that comes from a register read port.

The offset is split across two three-bit fields of the instruction. Bits 8 to 6 form the upper half and bits 2 to 0 the lower half. The joined six-bit value is read as two's complement and sign-extended to the address width. Two select bits steer the update. `jumpSel` chooses an absolute jump over a relative branch. `condSel` chooses which flag a branch tests: negative or zero. All arithmetic wraps modulo 2^16.

Top module: `pc_seq`

## Requirements
- R1: A synchronous active-high reset drives `pcOut` to 0 on the next rising edge.
- R2: When `loadEn` is 0, `pcOut` advances by 1 on each rising edge, wrapping from 0xFFFF to 0x0000.
- R3: When `loadEn` is 1 and `jumpSel` is 1, `pcOut` takes the value of `jumpTarget` on the next edge. The flags and the instruction word have no effect in this case.
- R4: When `loadEn` is 1, `jumpSel` is 0 and `condSel` is 1, the branch tests `flagNeg`. If the flag is set, `pcOut` becomes `pcOut` plus the offset. If it is clear, `pcOut` becomes `pcOut` plus 1.
- R5: When `loadEn` is 1, `jumpSel` is 0 and `condSel` is 0, the branch tests `flagZero` in the same way as R4.
- R6: The branch offset is {`instr[8:6]`, `instr[2:0]`}, read as a six-bit two's-complement value in the range −32..+31 and sign-extended to 16 bits. For example, PC 45 with field 110100 gives 33.
- R7: Offset addition wraps modulo 2^16 and the carry-out is dropped. For example, PC 2 with offset −5 gives 0xFFFD.
- R8: On a branch, the flag that is not selected has no effect on `pcOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Current instruction word (offset fields) |
| jumpTarget | input | 16 | Absolute jump address from register read port A |
| flagNeg | input | 1 | Source register value is negative |
| flagZero | input | 1 | Source register value is zero |
| loadEn | input | 1 | 1 = jump or branch, 0 = increment |
| jumpSel | input | 1 | 1 = absolute jump, 0 = relative branch |
| condSel | input | 1 | 1 = branch tests negative flag, 0 = tests zero flag |
| pcOut | output | 16 | Current instruction address |

## Verification
The next-address choice is purely combinational, and the only storage is the PC register. Every result therefore appears on `pcOut` exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and samples `pcOut` on the following falling edge. It compares the sample against a model that holds the previous PC and applies the requirement arithmetic. The model sweeps all 64 offset values under every flag and select combination. It starts each case from a PC loaded through a jump, so results one edge later are checked against a known base.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 6;

  typedef enum logic [1:0] {
    NEXT_INC  = 2'd0,
    NEXT_REL  = 2'd1,
    NEXT_ABS  = 2'd2
  } nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     doReset;
  } pcStrobe_t;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic       rst,
  input  logic       flagNeg,
  input  logic       flagZero,
  input  logic       loadEn,
  input  logic       jumpSel,
  input  logic       condSel,
  output pcStrobe_t  strobe
);
  logic condMet;

  always_comb begin
    condMet = condSel ? flagNeg : flagZero;
    strobe.doReset = rst;
    if (!loadEn)      strobe.sel = NEXT_INC;
    else if (jumpSel) strobe.sel = NEXT_ABS;
    else if (condMet) strobe.sel = NEXT_REL;
    else              strobe.sel = NEXT_INC;
  end
endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W
) (
  input  logic          clk,
  input  logic [15:0]   instr,
  input  logic [AW-1:0] jumpTarget,
  input  pcStrobe_t     strobe,
  output logic [AW-1:0] pcOut
);
  localparam int HALF = OW / 2;

  logic [OW-1:0] offRaw;
  logic [AW-1:0] offExt;
  logic [AW-1:0] pcReg;
  logic [AW-1:0] pcNext;

  assign offRaw = {instr[6+HALF-1:6], instr[HALF-1:0]};
  assign offExt = {{(AW-OW){offRaw[OW-1]}}, offRaw};

  always_comb begin
    unique case (strobe.sel)
      NEXT_REL: pcNext = pcReg + offExt;
      NEXT_ABS: pcNext = jumpTarget;
      default:  pcNext = pcReg + AW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.doReset) pcReg <= '0;
    else                pcReg <= pcNext;
  end

  assign pcOut = pcReg;
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] instr,
  input  logic [15:0] jumpTarget,
  input  logic        flagNeg,
  input  logic        flagZero,
  input  logic        loadEn,
  input  logic        jumpSel,
  input  logic        condSel,
  output logic [15:0] pcOut
);
  pcStrobe_t strobe;

  pc_seq_ctrl ctrl_i (
    .rst(rst), .flagNeg(flagNeg), .flagZero(flagZero),
    .loadEn(loadEn), .jumpSel(jumpSel), .condSel(condSel),
    .strobe(strobe)
  );

  pc_seq_dp #(.AW(16), .OW(6)) dp_i (
    .clk(clk), .instr(instr), .jumpTarget(jumpTarget),
    .strobe(strobe), .pcOut(pcOut)
  );
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic [15:0] jumpTarget,
  input logic        flagNeg,
  input logic        flagZero,
  input logic        loadEn,
  input logic        jumpSel,
  input logic        condSel,
  input logic [15:0] pcOut
);
  logic [15:0] offs;
  assign offs = {{10{instr[8]}}, instr[8:6], instr[2:0]};

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pcOut == 16'h0);

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> pcOut == $past(pcOut) + 16'd1);

  a_r3_jump_load: assert property (@(posedge clk) disable iff (rst)
    (loadEn && jumpSel) |=> pcOut == $past(jumpTarget));

  a_r4_neg_branch: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !jumpSel && condSel) |=>
      pcOut == ($past(flagNeg) ? $past(pcOut) + $past(offs) : $past(pcOut) + 16'd1));

  a_r5_zero_branch: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !jumpSel && !condSel) |=>
      pcOut == ($past(flagZero) ? $past(pcOut) + $past(offs) : $past(pcOut) + 16'd1));
endmodule

bind pc_seq pc_seq_chk chk_i (.*);

// File: tb/pc_seq_tb_top.sv
module pc_seq_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic [15:0] instr = 0, jumpTarget = 0;
  logic flagNeg = 0, flagZero = 0, loadEn = 0, jumpSel = 0, condSel = 0;
  logic [15:0] pcOut;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pc_seq dut_i (.*);

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (pcOut !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, pcOut, exp);
    end
  endtask

  // apply inputs at negedge, wait one full cycle, sample at next negedge
  task automatic step(input logic le, input logic js, input logic cs,
                      input logic n, input logic z,
                      input logic [15:0] ir, input logic [15:0] jt);
    loadEn = le; jumpSel = js; condSel = cs; flagNeg = n; flagZero = z;
    instr = ir; jumpTarget = jt;
    @(negedge clk);
  endtask

  task automatic setPc(input logic [15:0] v);
    step(1, 1, 0, 0, 0, 16'h0, v);
  endtask

  function automatic logic [15:0] enc(input int o);
    logic [5:0] f;
    f = 6'(o);
    return {7'h55, f[5:3], 3'b101, f[2:0]};
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 16'h0);
    rst = 0;
    step(0, 0, 0, 0, 0, 0, 0); check("R2", 16'd1);
    step(0, 1, 1, 1, 1, 16'hFFFF, 16'h1234); check("R2", 16'd2);
    setPc(16'hFFFF); check("R3", 16'hFFFF);
    step(0, 0, 0, 0, 0, 0, 0); check("R2", 16'h0000);
    setPc(16'hBEEF); check("R3", 16'hBEEF);
    step(1, 1, 1, 1, 1, enc(-1), 16'h0042); check("R3", 16'h0042);
    // worked example
    setPc(16'd45);
    step(1, 0, 1, 1, 0, {7'h0, 3'b110, 3'b000, 3'b100}, 0); check("R6", 16'd33);
    // wrap below zero
    setPc(16'd2);
    step(1, 0, 0, 0, 1, enc(-5), 0); check("R7", 16'hFFFD);
    setPc(16'hFFF0);
    step(1, 0, 1, 1, 0, enc(31), 0); check("R7", 16'h000F);
    // sweep all offsets, both conditions, all flag pairs
    for (int o = -32; o < 32; o++) begin
      for (int c = 0; c < 2; c++) begin
        for (int f = 0; f < 4; f++) begin
          logic [15:0] base, exp;
          logic n, z, taken;
          base = 16'h8000 + 16'(o * 7);
          n = f[1]; z = f[0];
          taken = c ? n : z;
          exp = taken ? base + 16'(o) : base + 16'd1;
          setPc(base);
          step(1, 0, c[0], n, z, enc(o), 16'hDEAD);
          if (c == 1) check(taken ? "R4 R6" : "R4 R8", exp);
          else        check(taken ? "R5 R6" : "R5 R8", exp);
        end
      end
    end
    rst = 1; step(0, 0, 0, 0, 0, 0, 0); check("R1", 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule